// File: doc/BRIEF.md
# Page Entry Access Check Unit

This unit judges one memory access against one page-table entry word. Each request carries the access kind (read or write), the privilege of the requester (user or supervisor), the entry word, and two global controls: a cache-off switch and a write-protect switch. One cycle after the request is accepted, the unit presents a registered verdict. The verdict holds a fault flag with a 2-bit reason, the caching attributes that apply to the access, and, when needed, a strobe carrying the entry word rewritten with its accessed flag set.

The unit sits between a page walker and the memory pipeline. The walker offers the fetched entry together with the access that caused the walk. The memory side takes the verdict and the caching attributes. When the write-back strobe is raised, the updated entry is sent back to memory. The accessed flag is sticky: this unit only ever sets it, so a write-back appears only on the first successful access to a page whose flag is still clear.

Entry bit positions used throughout: bit 0 present, bit 1 writable, bit 2 user page, bit 3 write-through, bit 4 no-cache, bit 5 accessed. Reason codes: 0 none, 1 not present, 2 privilege, 3 write.

Top module: `pte_access_check`

## Requirements
- R1: An entry with bit 0 clear yields reason 1 (not present) with the fault flag set, and no write-back strobe. This takes priority over every other fault.
- R2: A user access (req_user_i=1) to an entry with bit 2 clear yields reason 2 (privilege) with the fault flag set. This takes priority over a write fault.
- R3: A user write to a user page with bit 1 clear yields reason 3 (write) with the fault flag set.
- R4: A supervisor write to an entry with bit 1 clear yields reason 3 only when wr_prot_i=1; with wr_prot_i=0 it yields reason 0. Reads to a present page, and any access that R2 and R3 permit, yield reason 0 with the fault flag clear.
- R5: With cache_off_i=0, rsp_cacheable_o is the inverse of entry bit 4 and rsp_wthru_o equals entry bit 3.
- R6: With cache_off_i=1, rsp_cacheable_o is 0 and rsp_wthru_o is 0, whatever entry bits 3 and 4 hold.
- R7: An access with reason 0 to an entry whose bit 5 is 0 raises wb_valid_o together with the verdict. wb_pte_o is then the entry with bit 5 set and all other bits unchanged.
- R8: wb_valid_o stays low for any faulting access and for any entry whose bit 5 is already 1.
- R9: The verdict appears on rsp_valid_o in the cycle after a request handshake (req_valid_i and req_ready_o both high). It stays until a cycle with rsp_ready_i high, after which rsp_valid_o falls unless a new request was accepted in that same cycle.
- R10: While a verdict is held with rsp_ready_i low, req_ready_o is low and all verdict outputs are stable. req_ready_o is high whenever no verdict is held or the held one is being taken.
- R11: After reset, rsp_valid_o and wb_valid_o are 0 and req_ready_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request offered |
| req_ready_o | output | 1 | Request can be accepted |
| req_write_i | input | 1 | 1 = write access, 0 = read |
| req_user_i | input | 1 | 1 = user privilege, 0 = supervisor |
| req_pte_i | input | PTE_W | Page-table entry word |
| cache_off_i | input | 1 | Global cache-off control |
| wr_prot_i | input | 1 | Global write-protect control for supervisor writes |
| rsp_valid_o | output | 1 | Verdict present |
| rsp_ready_i | input | 1 | Verdict taken |
| rsp_fault_o | output | 1 | Access refused |
| rsp_reason_o | output | 2 | 0 none, 1 not present, 2 privilege, 3 write |
| rsp_cacheable_o | output | 1 | Access may be cached |
| rsp_wthru_o | output | 1 | Write-through policy applies |
| wb_valid_o | output | 1 | Updated entry must be written back |
| wb_pte_o | output | PTE_W | Entry word with accessed flag set |

## Verification
The hand-over of a held verdict and the acceptance of the next request can happen on the same clock edge. The bench provokes this by stalling rsp_ready_i while a not-present verdict is held and a second, permitted request with a clear accessed flag waits at the input. It then raises rsp_ready_i and checks that req_ready_o rises in the same cycle. One cycle later it checks that the new verdict, along with its write-back strobe and updated word, has replaced the old one without any empty cycle between them. During the stall it also checks that req_ready_o stays low and that the held verdict does not change.

// File: rtl/pte_chk_pkg.sv
package pte_chk_pkg;
  typedef enum logic [1:0] {
    RSN_NONE   = 2'd0,
    RSN_ABSENT = 2'd1,
    RSN_PRIV   = 2'd2,
    RSN_WRITE  = 2'd3
  } reason_e;

  localparam int unsigned BIT_PRESENT  = 0;
  localparam int unsigned BIT_WRITABLE = 1;
  localparam int unsigned BIT_USER     = 2;
  localparam int unsigned BIT_WTHRU    = 3;
  localparam int unsigned BIT_NOCACHE  = 4;
  localparam int unsigned BIT_ACCESSED = 5;
  localparam int unsigned PTE_MIN_W    = 6;

  typedef struct packed {
    reason_e reason;
    logic    cacheable;
    logic    wthru;
    logic    set_acc;
  } verdict_t;
endpackage

// File: rtl/pte_prot_chk.sv
module pte_prot_chk
  import pte_chk_pkg::*;
#(
  parameter int unsigned PTE_W = 32
) (
  input  logic [PTE_W-1:0] pte_i,
  input  logic             write_i,
  input  logic             user_i,
  input  logic             wr_prot_i,
  output reason_e          reason_o
);
  logic present, writable, user_pg, wr_blocked;

  assign present    = pte_i[BIT_PRESENT];
  assign writable   = pte_i[BIT_WRITABLE];
  assign user_pg    = pte_i[BIT_USER];
  // supervisor writes bypass read-only unless write-protect is on
  assign wr_blocked = write_i && !writable && (user_i || wr_prot_i);

  always_comb begin
    if (!present)              reason_o = RSN_ABSENT;
    else if (user_i && !user_pg) reason_o = RSN_PRIV;
    else if (wr_blocked)       reason_o = RSN_WRITE;
    else                       reason_o = RSN_NONE;
  end
endmodule

// File: rtl/pte_cache_attr.sv
module pte_cache_attr
  import pte_chk_pkg::*;
#(
  parameter int unsigned PTE_W = 32
) (
  input  logic [PTE_W-1:0] pte_i,
  input  logic             cache_off_i,
  output logic             cacheable_o,
  output logic             wthru_o
);
  logic nocache_eff;

  // global cache-off forces the no-cache bit and masks the policy bit
  assign nocache_eff = cache_off_i | pte_i[BIT_NOCACHE];
  assign cacheable_o = ~nocache_eff;
  assign wthru_o     = ~cache_off_i & pte_i[BIT_WTHRU];
endmodule

// File: rtl/pte_acc_upd.sv
module pte_acc_upd
  import pte_chk_pkg::*;
#(
  parameter int unsigned PTE_W = 32
) (
  input  logic [PTE_W-1:0] pte_i,
  input  reason_e          reason_i,
  output logic             set_acc_o,
  output logic [PTE_W-1:0] pte_upd_o
);
  localparam logic [PTE_W-1:0] ACC_MASK = PTE_W'(1) << BIT_ACCESSED;

  assign set_acc_o = (reason_i == RSN_NONE) && !pte_i[BIT_ACCESSED];
  assign pte_upd_o = pte_i | ACC_MASK;
endmodule

// File: rtl/pte_rsp_reg.sv
module pte_rsp_reg
  import pte_chk_pkg::*;
#(
  parameter int unsigned PTE_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             take_i,
  input  verdict_t         verdict_i,
  input  logic [PTE_W-1:0] pte_i,
  output logic             valid_o,
  output verdict_t         verdict_o,
  output logic [PTE_W-1:0] pte_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      verdict_o <= '0;
      pte_o     <= '0;
    end else if (load_i) begin
      valid_o   <= 1'b1;
      verdict_o <= verdict_i;
      pte_o     <= pte_i;
    end else if (take_i) begin
      valid_o   <= 1'b0;
    end
  end
endmodule

// File: rtl/pte_access_check.sv
module pte_access_check
  import pte_chk_pkg::*;
#(
  parameter int unsigned PTE_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic             req_write_i,
  input  logic             req_user_i,
  input  logic [PTE_W-1:0] req_pte_i,
  input  logic             cache_off_i,
  input  logic             wr_prot_i,
  output logic             rsp_valid_o,
  input  logic             rsp_ready_i,
  output logic             rsp_fault_o,
  output logic [1:0]       rsp_reason_o,
  output logic             rsp_cacheable_o,
  output logic             rsp_wthru_o,
  output logic             wb_valid_o,
  output logic [PTE_W-1:0] wb_pte_o
);
  reason_e          reason;
  logic             cacheable, wthru, set_acc;
  logic [PTE_W-1:0] pte_upd;
  logic             fire, take;
  verdict_t         verdict_d, verdict_q;

  if (PTE_W < PTE_MIN_W) begin : g_bad_width
    initial $error("PTE_W too small");
  end

  pte_prot_chk #(.PTE_W(PTE_W)) i_prot (
    .pte_i     (req_pte_i),
    .write_i   (req_write_i),
    .user_i    (req_user_i),
    .wr_prot_i (wr_prot_i),
    .reason_o  (reason)
  );

  pte_cache_attr #(.PTE_W(PTE_W)) i_attr (
    .pte_i       (req_pte_i),
    .cache_off_i (cache_off_i),
    .cacheable_o (cacheable),
    .wthru_o     (wthru)
  );

  pte_acc_upd #(.PTE_W(PTE_W)) i_acc (
    .pte_i     (req_pte_i),
    .reason_i  (reason),
    .set_acc_o (set_acc),
    .pte_upd_o (pte_upd)
  );

  assign verdict_d = '{reason: reason, cacheable: cacheable, wthru: wthru, set_acc: set_acc};

  // a held verdict blocks intake unless it leaves this cycle
  assign req_ready_o = !rsp_valid_o || rsp_ready_i;
  assign fire        = req_valid_i && req_ready_o;
  assign take        = rsp_valid_o && rsp_ready_i;

  pte_rsp_reg #(.PTE_W(PTE_W)) i_rsp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (fire),
    .take_i    (take),
    .verdict_i (verdict_d),
    .pte_i     (pte_upd),
    .valid_o   (rsp_valid_o),
    .verdict_o (verdict_q),
    .pte_o     (wb_pte_o)
  );

  assign rsp_reason_o    = verdict_q.reason;
  assign rsp_fault_o     = verdict_q.reason != RSN_NONE;
  assign rsp_cacheable_o = verdict_q.cacheable;
  assign rsp_wthru_o     = verdict_q.wthru;
  assign wb_valid_o      = rsp_valid_o && verdict_q.set_acc;
endmodule

// File: rtl/pte_access_check_sva.sv
module pte_access_check_sva #(
  parameter int unsigned PTE_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic             req_ready_o,
  input logic             req_write_i,
  input logic             req_user_i,
  input logic [PTE_W-1:0] req_pte_i,
  input logic             cache_off_i,
  input logic             wr_prot_i,
  input logic             rsp_valid_o,
  input logic             rsp_ready_i,
  input logic             rsp_fault_o,
  input logic [1:0]       rsp_reason_o,
  input logic             rsp_cacheable_o,
  input logic             rsp_wthru_o,
  input logic             wb_valid_o,
  input logic [PTE_W-1:0] wb_pte_o
);
  logic hs;
  assign hs = req_valid_i && req_ready_o;

  p_absent_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hs && !req_pte_i[0] |=> rsp_reason_o == 2'd1 && rsp_fault_o && !wb_valid_o);

  p_priv_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hs && req_pte_i[0] && req_user_i && !req_pte_i[2] |=> rsp_reason_o == 2'd2);

  p_cache_off_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hs && cache_off_i |=> !rsp_cacheable_o && !rsp_wthru_o);

  p_wb_word_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_o |-> wb_pte_o[5]);

  p_wb_clean_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_o |-> rsp_valid_o && !rsp_fault_o);

  p_latency_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hs |=> rsp_valid_o);

  p_stall_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_ready_i |-> !req_ready_o);

  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_ready_i |=> rsp_valid_o && $stable(rsp_reason_o)
      && $stable(rsp_cacheable_o) && $stable(rsp_wthru_o) && $stable(wb_valid_o));

  always_comb begin
    if (!rst_ni) a_reset_r11: assert (!rsp_valid_o && !wb_valid_o);
  end
endmodule

bind pte_access_check pte_access_check_sva #(.PTE_W(PTE_W)) i_sva (.*);

// File: tb/test_pte_access_check.sv
module test_pte_access_check;
  localparam int unsigned PTE_W = 32;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             req_valid_i = 1'b0, req_ready_o, req_write_i = 1'b0, req_user_i = 1'b0;
  logic [PTE_W-1:0] req_pte_i = '0;
  logic             cache_off_i = 1'b0, wr_prot_i = 1'b0;
  logic             rsp_valid_o, rsp_ready_i = 1'b1, rsp_fault_o;
  logic [1:0]       rsp_reason_o;
  logic             rsp_cacheable_o, rsp_wthru_o, wb_valid_o;
  logic [PTE_W-1:0] wb_pte_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pte_access_check #(.PTE_W(PTE_W)) i_pte_access_check (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
    .req_write_i(req_write_i), .req_user_i(req_user_i), .req_pte_i(req_pte_i),
    .cache_off_i(cache_off_i), .wr_prot_i(wr_prot_i),
    .rsp_valid_o(rsp_valid_o), .rsp_ready_i(rsp_ready_i),
    .rsp_fault_o(rsp_fault_o), .rsp_reason_o(rsp_reason_o),
    .rsp_cacheable_o(rsp_cacheable_o), .rsp_wthru_o(rsp_wthru_o),
    .wb_valid_o(wb_valid_o), .wb_pte_o(wb_pte_o)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_reason(logic w, logic u, logic [PTE_W-1:0] p, logic wp);
    if (!p[0]) return 2'd1;
    if (u && !p[2]) return 2'd2;
    if (w && !p[1] && (u || wp)) return 2'd3;
    return 2'd0;
  endfunction

  // issue one request, check verdict one cycle later
  task automatic run_one(input logic w, input logic u, input logic [PTE_W-1:0] p,
                         input logic cd, input logic wp,
                         input string tr, input string tc, input string ta);
    logic [1:0] er;
    logic       ewb;
    @(negedge clk);
    req_write_i = w; req_user_i = u; req_pte_i = p;
    cache_off_i = cd; wr_prot_i = wp; req_valid_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid_i = 1'b0;
    er  = exp_reason(w, u, p, wp);
    ewb = (er == 2'd0) && !p[5];
    chk({"R9 valid ", tr}, rsp_valid_o, 1'b1);
    chk({tr, " reason"}, rsp_reason_o, er);
    chk({tr, " fault"}, rsp_fault_o, er != 2'd0);
    chk({tc, " cacheable"}, rsp_cacheable_o, cd ? 1'b0 : !p[4]);
    chk({tc, " wthru"}, rsp_wthru_o, cd ? 1'b0 : p[3]);
    chk({ta, " wb_valid"}, wb_valid_o, ewb);
    if (ewb) chk({ta, " wb_pte"}, wb_pte_o, p | 32'h20);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R11 rsp_valid", rsp_valid_o, 1'b0);
    chk("R11 wb_valid", wb_valid_o, 1'b0);
    chk("R11 req_ready", req_ready_o, 1'b1);
  endtask

  task automatic t_absent;
    run_one(1, 1, 32'h0000_0002, 0, 1, "R1", "R5", "R8");
    run_one(0, 0, 32'hFFFF_FFDE, 0, 0, "R1", "R5", "R8");
  endtask

  task automatic t_priv;
    run_one(0, 1, 32'h0000_0003, 0, 0, "R2", "R5", "R8");
    run_one(1, 1, 32'h0000_0001, 0, 0, "R2", "R5", "R8");
  endtask

  task automatic t_user_write;
    run_one(1, 1, 32'h0000_0005, 0, 0, "R3", "R5", "R8");
    run_one(1, 1, 32'h0000_0007, 0, 0, "R4", "R5", "R7");
    run_one(0, 1, 32'h0000_0005, 0, 0, "R4", "R5", "R7");
  endtask

  task automatic t_sup_write;
    run_one(1, 0, 32'h0000_0001, 0, 0, "R4", "R5", "R7");
    run_one(1, 0, 32'h0000_0001, 0, 1, "R4", "R5", "R8");
    run_one(0, 0, 32'h0000_0001, 0, 1, "R4", "R5", "R7");
  endtask

  task automatic t_cache;
    run_one(0, 0, 32'h0000_0029, 0, 0, "R4", "R5", "R8");
    run_one(0, 0, 32'h0000_0031, 0, 0, "R4", "R5", "R8");
    run_one(0, 0, 32'h0000_0039, 0, 0, "R4", "R5", "R8");
  endtask

  task automatic t_cache_off;
    run_one(0, 0, 32'h0000_0009, 1, 0, "R4", "R6", "R7");
    run_one(0, 0, 32'h0000_0001, 1, 0, "R4", "R6", "R7");
  endtask

  task automatic t_accessed;
    run_one(1, 1, 32'hABC0_0007, 0, 0, "R4", "R5", "R7");
    run_one(1, 1, 32'hABC0_0027, 0, 0, "R4", "R5", "R8");
    run_one(1, 1, 32'hABC0_0005, 0, 0, "R3", "R5", "R8");
  endtask

  // stall a not-present verdict, then hand over to a permitted one
  task automatic t_backpressure;
    @(negedge clk);
    rsp_ready_i = 1'b0;
    req_write_i = 0; req_user_i = 0; req_pte_i = 32'h0000_0000;
    cache_off_i = 0; wr_prot_i = 0; req_valid_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_pte_i = 32'h1234_0001;
    chk("R10 ready low", req_ready_o, 1'b0);
    chk("R9 held valid", rsp_valid_o, 1'b1);
    chk("R10 held reason", rsp_reason_o, 2'd1);
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      chk("R10 still low", req_ready_o, 1'b0);
      chk("R10 stable reason", rsp_reason_o, 2'd1);
      chk("R10 stable wb", wb_valid_o, 1'b0);
    end
    rsp_ready_i = 1'b1;
    #1;
    chk("R10 ready on take", req_ready_o, 1'b1);
    @(posedge clk);
    @(negedge clk);
    req_valid_i = 1'b0;
    chk("R9 next valid", rsp_valid_o, 1'b1);
    chk("R9 next reason", rsp_reason_o, 2'd0);
    chk("R7 next wb", wb_valid_o, 1'b1);
    chk("R7 next word", wb_pte_o, 32'h1234_0021);
    @(negedge clk);
    chk("R9 drained", rsp_valid_o, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_ni = 1'b1;
    t_reset;
    t_absent;
    t_priv;
    t_user_write;
    t_sup_write;
    t_cache;
    t_cache_off;
    t_accessed;
    t_backpressure;
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule